// File: doc/BRIEF.md
# Compare-Match Toggle Channel

This block is a single channel of a counter array. It compares a free-running timebase, delivered on an input port, against a compare value that software writes one byte at a time. When the channel runs in high-speed toggle mode, each new equality between the two inverts the output pin, sets a sticky match flag and, if enabled, raises an interrupt request. Writing the low compare byte disarms the channel, and writing the high byte arms it again. A half-updated compare value therefore cannot produce a false match.

A two-state sequencer drives the output. In state HOLD the pin keeps its value. The transition *arm* (HOLD to RUN) happens on the first clock edge at which the decoded mode is true, and it loads the pin with 1. In state RUN, each match pulse inverts the pin. The transition *disarm* (RUN to HOLD) happens on any edge at which the decoded mode is false.

The register map has four entries:

| Address | Register | Contents |
|---|---|---|
| 0 | Mode | bit7 = compare enable, bit3 = PWM select, bit2 = toggle, bit1 = match, bit0 = interrupt enable |
| 1 | Compare low | low byte of the compare value |
| 2 | Compare high | high byte of the compare value |
| 3 | Status | bit0 = match flag |

Top module: `cmt_channel`

## Requirements
- R1: In state RUN, the output pin inverts on the clock edge at which the timebase first equals {compare high, compare low}. The new value is visible after that edge.
- R2: The mode is decoded as active only when mode bits 7, 2 and 1 are all 1 and bit 3 is 0. With any other combination, the pin holds its value and matches neither toggle it nor set the flag.
- R3: A write to address 1 stores the byte and clears mode bit 7 on the same edge.
- R4: A write to address 2 stores the byte and sets mode bit 7 on the same edge.
- R5: bus_rdata shows, without a clock, the register selected by bus_addr. Address 3 reads as {7'b0, flag}.
- R6: The pin is 1 after reset. The arm transition loads the pin with 1, and a match on the arm edge neither toggles the pin nor sets the flag.
- R7: Matching is edge-qualified. While the timebase stays equal to the compare value over further cycles, no further toggle or flag set occurs.
- R8: A match in RUN sets the status flag. The flag stays set until a write to address 3 with bit0 = 0. A write with bit0 = 1 has no effect. A set on the same edge as a clear wins.
- R9: irq is 1 exactly when the status flag and mode bit 0 are both 1.
- R10: Reset clears the mode, compare and status registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timebase | input | 16 | Free-running counter value |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for bus_addr |
| tog_out | output | 1 | Toggle output pin |
| irq | output | 1 | Interrupt request |

## Verification
A wrong state or pin register shows up at tog_out within one edge of the next match, the next arm or the next mode change. The bench sweeps the timebase across several compare values, including values that hold for two cycles, and compares the pin every cycle with a count of expected edges.

A corrupted edge-detector register shows up as a missing toggle or an extra toggle, and the per-cycle check catches it at the following edge. Faults in the flag and the enable bit show up on bus_rdata and irq in the cycle right after the write or match that caused them.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    typedef enum logic [1:0] {
        A_MODE = 2'd0,
        A_CMPL = 2'd1,
        A_CMPH = 2'd2,
        A_STAT = 2'd3
    } reg_addr_e;

    localparam int B_CEN = 7;
    localparam int B_PWM = 3;
    localparam int B_TOG = 2;
    localparam int B_MAT = 1;
    localparam int B_IEN = 0;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } ch_state_e;
endpackage

// File: rtl/cmt_regs.sv
module cmt_regs
    import cmt_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              set_flag,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              mode_on,
    output logic              irq_en,
    output logic              flag
);
    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] cmp_lo_q;
    logic [DATA_W-1:0] cmp_hi_q;
    logic              flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            cmp_lo_q <= '0;
            cmp_hi_q <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (bus_we) begin
                unique case (reg_addr_e'(bus_addr))
                    A_MODE: mode_q <= bus_wdata;
                    A_CMPL: begin
                        cmp_lo_q      <= bus_wdata;
                        mode_q[B_CEN] <= 1'b0;
                    end
                    A_CMPH: begin
                        cmp_hi_q      <= bus_wdata;
                        mode_q[B_CEN] <= 1'b1;
                    end
                    A_STAT: if (!bus_wdata[0]) flag_q <= 1'b0;
                endcase
            end
            if (set_flag) flag_q <= 1'b1;
        end
    end

    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            A_MODE:  bus_rdata = mode_q;
            A_CMPL:  bus_rdata = cmp_lo_q;
            A_CMPH:  bus_rdata = cmp_hi_q;
            A_STAT:  bus_rdata = {{(DATA_W-1){1'b0}}, flag_q};
        endcase
    end

    assign cmp_val = {cmp_hi_q, cmp_lo_q};
    assign mode_on = mode_q[B_CEN] & mode_q[B_MAT] & mode_q[B_TOG] & ~mode_q[B_PWM];
    assign irq_en  = mode_q[B_IEN];
    assign flag    = flag_q;

    p_low_disarm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CMPL) |=> !mode_q[B_CEN]);

    p_high_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CMPH) |=> mode_q[B_CEN]);

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(bus_we && bus_addr == A_STAT && !bus_wdata[0])) |=> flag_q);

    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_flag |=> flag_q);
endmodule

// File: rtl/cmt_match.sv
module cmt_match #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] timebase,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             match_pulse
);
    logic eq;
    logic eq_q;

    assign eq = (timebase == cmp_val);

    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq;
    end

    assign match_pulse = eq & ~eq_q;

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> !match_pulse);
endmodule

// File: rtl/cmt_fsm.sv
module cmt_fsm
    import cmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_on,
    input  logic match_pulse,
    output logic set_flag,
    output logic pin
);
    ch_state_e state_q;
    ch_state_e state_d;
    logic      pin_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (mode_on)  state_d = ST_RUN;
            ST_RUN:  if (!mode_on) state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b1;
        end else begin
            unique case (state_q)
                ST_HOLD: if (mode_on) pin_q <= 1'b1;
                ST_RUN:  if (mode_on && match_pulse) pin_q <= ~pin_q;
            endcase
        end
    end

    assign set_flag = (state_q == ST_RUN) && mode_on && match_pulse;
    assign pin      = pin_q;

    p_arm_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && mode_on) |=> pin_q);

    p_hold_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_on |=> $stable(pin_q));

    p_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && mode_on && match_pulse) |=> (pin_q != $past(pin_q)));
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel #(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  timebase,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tog_out,
    output logic              irq
);
    logic [CNT_W-1:0] cmp_val;
    logic             mode_on;
    logic             irq_en;
    logic             flag;
    logic             set_flag;
    logic             match_pulse;

    cmt_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .set_flag  (set_flag),
        .bus_rdata (bus_rdata),
        .cmp_val   (cmp_val),
        .mode_on   (mode_on),
        .irq_en    (irq_en),
        .flag      (flag)
    );

    cmt_match #(.CNT_W(CNT_W)) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .timebase    (timebase),
        .cmp_val     (cmp_val),
        .match_pulse (match_pulse)
    );

    cmt_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_on     (mode_on),
        .match_pulse (match_pulse),
        .set_flag    (set_flag),
        .pin         (tog_out)
    );

    assign irq = flag & irq_en;

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (bus_addr != 2'd3 || bus_rdata[0]));
endmodule

// File: tb/cmt_channel_test.sv
`timescale 1ns/1ps
module cmt_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timebase = 16'hFFFF;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic        tog_out;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmt_channel uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .timebase  (timebase),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .tog_out   (tog_out),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] cval [3];
        logic        exp_pin;
        logic        p;
        logic [15:0] prev;
        logic [15:0] c;
        logic [7:0]  bad_modes [4];
        cval[0] = 16'h0005; cval[1] = 16'h01FF; cval[2] = 16'hA55A;
        bad_modes[0] = 8'h8E; bad_modes[1] = 8'h84; bad_modes[2] = 8'h82; bad_modes[3] = 8'h06;

        repeat (3) tick();
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            chk("R10 reset register", {8'd0, d}, 16'd0);
        end
        chk("R6 pin after reset", {15'd0, tog_out}, 16'd1);
        chk("R9 irq after reset", {15'd0, irq}, 16'd0);

        wr(2'd0, 8'h06);
        rd(2'd0, d);
        chk("R5 mode readback", {8'd0, d}, 16'h0006);

        c = 16'h0000;
        for (int r = 0; r < 3; r++) begin
            c = cval[r];
            timebase = 16'hFFFF;
            wr(2'd1, c[7:0]);
            rd(2'd0, d);
            chk("R3 low write clears enable", {8'd0, d}, 16'h0006);
            wr(2'd2, c[15:8]);
            rd(2'd0, d);
            chk("R4 high write sets enable", {8'd0, d}, 16'h0086);
            rd(2'd1, d);
            chk("R5 low byte readback", {8'd0, d}, {8'd0, c[7:0]});
            rd(2'd2, d);
            chk("R5 high byte readback", {8'd0, d}, {8'd0, c[15:8]});
            tick();
            exp_pin = 1'b1;
            chk("R6 pin after arm", {15'd0, tog_out}, 16'd1);
            prev = timebase;
            for (int i = 0; i < 64; i++) begin
                timebase = c - 16'd10 + 16'(i / 2);
                tick();
                if (timebase == c && prev != c) exp_pin = ~exp_pin;
                prev = timebase;
                chk("R1 R7 sweep pin", {15'd0, tog_out}, {15'd0, exp_pin});
            end
            rd(2'd3, d);
            chk("R8 flag set by match", {8'd0, d}, 16'd1);
            chk("R9 irq masked", {15'd0, irq}, 16'd0);
            wr(2'd3, 8'h00);
            rd(2'd3, d);
            chk("R8 flag cleared by zero write", {8'd0, d}, 16'd0);
        end

        wr(2'd0, 8'h87);
        chk("R9 irq low with no flag", {15'd0, irq}, 16'd0);
        p = tog_out;
        timebase = c;
        tick();
        chk("R1 toggle on match", {15'd0, tog_out}, {15'd0, ~p});
        chk("R9 irq raised", {15'd0, irq}, 16'd1);
        wr(2'd3, 8'h01);
        rd(2'd3, d);
        chk("R8 write of one keeps flag", {8'd0, d}, 16'd1);
        wr(2'd3, 8'h00);
        chk("R9 irq drops after clear", {15'd0, irq}, 16'd0);

        timebase = c + 16'd1; tick();
        timebase = c; tick();
        chk("R1 second toggle drives pin low", {15'd0, tog_out}, 16'd0);
        wr(2'd3, 8'h00);

        for (int m = 0; m < 4; m++) begin
            wr(2'd0, bad_modes[m]);
            p = tog_out;
            timebase = c + 16'd1; tick();
            timebase = c; tick();
            chk("R2 pin held in other mode", {15'd0, tog_out}, {15'd0, p});
            rd(2'd3, d);
            chk("R2 no flag in other mode", {8'd0, d}, 16'd0);
        end

        timebase = c + 16'd1;
        wr(2'd0, 8'h86);
        timebase = c;
        tick();
        chk("R6 arm loads one", {15'd0, tog_out}, 16'd1);
        rd(2'd3, d);
        chk("R6 match on arm edge ignored", {8'd0, d}, 16'd0);
        tick();
        chk("R7 held equality no toggle", {15'd0, tog_out}, 16'd1);

        wr(2'd1, c[7:0]);
        timebase = c + 16'd1; tick();
        timebase = c; tick();
        chk("R3 disarmed pin steady", {15'd0, tog_out}, 16'd1);
        rd(2'd3, d);
        chk("R3 disarmed no flag", {8'd0, d}, 16'd0);
        timebase = c + 16'd1;
        wr(2'd2, c[15:8]);
        tick();
        timebase = c; tick();
        chk("R4 rearmed toggles", {15'd0, tog_out}, 16'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule